// File: doc/BRIEF.md
# Time-Sliced Shared Instruction and Data Memory

This block lets a pipelined processor keep code and data in one single-port storage array while still doing an instruction fetch and a data access in every processor cycle. It runs from a fast clock at twice the processor rate and splits each processor cycle into two slots. In the first slot the array is addressed by the program counter and the fetched word is captured. In the second slot the array is addressed by the data address and either a load is captured or, when the write enable is high, a store is made.

The array is made of two 16-bit banks at the same index. The upper bank holds bits 31:16 of a word and the lower bank holds bits 15:0. Addresses count words. An address at or above the depth wraps modulo the depth. Both outputs come from registers. The fetched word is steady through the second slot, and the load result is ready when the processor cycle ends. A slot flag output tells the processor clock domain which half of its cycle is running.

Top module: `dual_slot_mem`

## Requirements
- R1: While `rst` is high, and on the first fast edge after it falls, `slot_o` is 0 and `instr_o` and `rdata_o` are 0.
- R2: After reset, `slot_o` toggles on every fast clock edge. The value 0 marks the fetch slot (first half of a processor cycle) and 1 marks the data slot.
- R3: The edge that ends a fetch slot loads `instr_o` with the word at `pc_addr`. `instr_o` then holds that value across the edge that ends the following data slot.
- R4: The edge that ends a data slot with `d_we` low loads `rdata_o` with the word at `d_addr`. `rdata_o` does not change on the edge that ends a fetch slot.
- R5: The edge that ends a data slot with `d_we` high stores `d_wdata` at `d_addr`, and `rdata_o` keeps its previous value on that edge.
- R6: `d_we` high during a fetch slot only (low by the end of the data slot) stores nothing.
- R7: If a cycle fetches from the address it writes, the fetch returns the old word and a fetch in the next cycle returns the new word.
- R8: A stored word comes back whole: bits 31:16 from the upper bank and bits 15:0 from the lower bank, each half kept apart.
- R9: Addresses wrap modulo `DEPTH`, so address `DEPTH+k` and `2*DEPTH+k` reach word `k`, both for fetches and for data accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, twice the processor clock rate |
| rst | input | 1 | Synchronous active-high reset |
| pc_addr | input | 32 | Word address for the instruction fetch |
| d_addr | input | 32 | Word address for the data access |
| d_we | input | 1 | Data write enable, sampled at the end of the data slot |
| d_wdata | input | 32 | Data to store |
| slot_o | output | 1 | 0 during the fetch slot, 1 during the data slot |
| instr_o | output | 32 | Fetched instruction word |
| rdata_o | output | 32 | Loaded data word |

## Verification
The bench writes to an address in the same cycle it fetches from that address. A design that put the write before the fetch, or let the write enable act in the fetch slot, would return the new word one cycle early. It also raises the write enable during the fetch slot only. A design that did not gate writes by slot would corrupt that word, and a later read would show it. Words have different upper and lower halves, so swapped or shared bank write data shows up as a wrong half. Accesses at `DEPTH+k` and `2*DEPTH+k` would hit a different word, or miss, if the index were not reduced modulo the depth. A store cycle must leave `rdata_o` unchanged, which catches a design that reloads the data register on writes.

// File: rtl/dual_slot_mem_pkg.sv
package dual_slot_mem_pkg;
  typedef enum logic {
    SLOT_FETCH = 1'b0,
    SLOT_DATA  = 1'b1
  } slot_e;
endpackage

// File: rtl/dsm_slot_gen.sv
module dsm_slot_gen
  import dual_slot_mem_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_e slot
);
  slot_e slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_FETCH;
    end else begin
      slot_q <= (slot_q == SLOT_FETCH) ? SLOT_DATA : SLOT_FETCH;
    end
  end

  assign slot = slot_q;
endmodule

// File: rtl/dsm_port_ctrl.sv
module dsm_port_ctrl
  import dual_slot_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  slot_e             slot,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_we,
  output logic [IDX_W-1:0]  idx,
  output logic              arr_we,
  output logic              ld_instr,
  output logic              ld_data
);
  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] wrapped;

  always_comb begin
    sel_addr = (slot == SLOT_FETCH) ? pc_addr : d_addr;
    wrapped  = sel_addr % ADDR_W'(DEPTH);
    idx      = wrapped[IDX_W-1:0];
    ld_instr = (slot == SLOT_FETCH);
    arr_we   = (slot == SLOT_DATA) && d_we;
    ld_data  = (slot == SLOT_DATA) && !d_we;
  end
endmodule

// File: rtl/dsm_bank.sv
module dsm_bank #(
  parameter int BANK_W = 16,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_half,
  input  logic              ld_instr,
  input  logic              ld_data,
  output logic [BANK_W-1:0] ins_half,
  output logic [BANK_W-1:0] dat_half
);
  logic [BANK_W-1:0] store [DEPTH];
  logic [BANK_W-1:0] ins_q;
  logic [BANK_W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[idx] <= wr_half;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q <= '0;
      dat_q <= '0;
    end else begin
      if (ld_instr) ins_q <= store[idx];
      if (ld_data)  dat_q <= store[idx];
    end
  end

  assign ins_half = ins_q;
  assign dat_half = dat_q;
endmodule

// File: rtl/dual_slot_mem.sv
module dual_slot_mem
  import dual_slot_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int BANK_W = 16,
  parameter int DEPTH  = 256
) (
  input  logic              clk_fast,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_we,
  input  logic [WORD_W-1:0] d_wdata,
  output logic              slot_o,
  output logic [WORD_W-1:0] instr_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int N_BANKS = WORD_W / BANK_W;

  slot_e            slot;
  logic [IDX_W-1:0] idx;
  logic             arr_we;
  logic             ld_instr;
  logic             ld_data;

  dsm_slot_gen i_slot (
    .clk  (clk_fast),
    .rst  (rst),
    .slot (slot)
  );

  dsm_port_ctrl #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) i_ctrl (
    .slot     (slot),
    .pc_addr  (pc_addr),
    .d_addr   (d_addr),
    .d_we     (d_we),
    .idx      (idx),
    .arr_we   (arr_we),
    .ld_instr (ld_instr),
    .ld_data  (ld_data)
  );

  // Bank 0 carries the low half of a word, the last bank the high half.
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    dsm_bank #(
      .BANK_W (BANK_W),
      .DEPTH  (DEPTH)
    ) i_bank (
      .clk      (clk_fast),
      .rst      (rst),
      .idx      (idx),
      .wr_en    (arr_we),
      .wr_half  (d_wdata[b*BANK_W +: BANK_W]),
      .ld_instr (ld_instr),
      .ld_data  (ld_data),
      .ins_half (instr_o[b*BANK_W +: BANK_W]),
      .dat_half (rdata_o[b*BANK_W +: BANK_W])
    );
  end

  assign slot_o = (slot == SLOT_DATA);
endmodule

// File: rtl/dual_slot_mem_chk.sv
module dual_slot_mem_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk_fast,
  input logic              rst,
  input logic              slot_o,
  input logic [WORD_W-1:0] instr_o,
  input logic [WORD_W-1:0] rdata_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_fast)
    rst |=> (!slot_o && instr_o == '0 && rdata_o == '0)); // R1

  AST_SLOT_TOGGLE: assert property (@(posedge clk_fast) disable iff (rst)
    !$past(rst) |-> (slot_o != $past(slot_o))); // R2

  AST_INSTR_HELD: assert property (@(posedge clk_fast) disable iff (rst)
    !slot_o |-> $stable(instr_o)); // R3

  AST_RDATA_HELD: assert property (@(posedge clk_fast) disable iff (rst)
    slot_o |-> $stable(rdata_o)); // R4
endmodule

bind dual_slot_mem dual_slot_mem_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_fast (clk_fast),
  .rst      (rst),
  .slot_o   (slot_o),
  .instr_o  (instr_o),
  .rdata_o  (rdata_o)
);

// File: tb/test_dual_slot_mem.sv
module test_dual_slot_mem;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  typedef struct {
    bit          chk;
    logic [31:0] val;
    string       req;
  } exp_t;

  logic        clk_fast = 1'b0;
  logic        rst      = 1'b1;
  logic [31:0] pc_addr  = '0;
  logic [31:0] d_addr   = '0;
  logic        d_we     = 1'b0;
  logic [31:0] d_wdata  = '0;
  logic        slot_o;
  logic [31:0] instr_o;
  logic [31:0] rdata_o;

  int n_checks = 0;
  int n_fails  = 0;

  exp_t        ins_exp[$];
  exp_t        dat_exp[$];
  logic [31:0] model [int];
  logic [31:0] last_rdata = '0;
  exp_t        last_ins;

  always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

  dual_slot_mem #(.DEPTH(DEPTH)) i_dual_slot_mem (
    .clk_fast (clk_fast),
    .rst      (rst),
    .pc_addr  (pc_addr),
    .d_addr   (d_addr),
    .d_we     (d_we),
    .d_wdata  (d_wdata),
    .slot_o   (slot_o),
    .instr_o  (instr_o),
    .rdata_o  (rdata_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic exp_t peek(input logic [31:0] a, input string req);
    exp_t e;
    int k = int'(a % DEPTH);
    e.req = req;
    e.chk = model.exists(k);
    e.val = e.chk ? model[k] : '0;
    return e;
  endfunction

  // Driver: called at a fetch-slot negedge + 1; returns at the next one.
  task automatic cycle(input logic [31:0] pc, input logic [31:0] da, input logic we,
                       input logic [31:0] wd, input bit early_we, input string req);
    exp_t ie;
    exp_t de;
    pc_addr = pc; d_addr = da; d_we = we; d_wdata = wd;
    ie = peek(pc, {req, " fetch R3"});
    ins_exp.push_back(ie);
    if (we && !early_we) begin
      de.chk = 1'b1; de.val = last_rdata; de.req = {req, " store keeps rdata R5"};
      model[int'(da % DEPTH)] = wd;
    end else begin
      de = peek(da, {req, " load R4"});
      if (de.chk) last_rdata = de.val;
    end
    dat_exp.push_back(de);
    @(negedge clk_fast); #1;
    check("R2 data slot flag", {31'd0, slot_o}, 32'd1);
    if (early_we) d_we = 1'b0;
    @(negedge clk_fast); #1;
    check("R2 fetch slot flag", {31'd0, slot_o}, 32'd0);
    d_we = 1'b0;
  endtask

  // Monitor: scoreboard compare as results appear.
  initial begin
    forever begin
      @(negedge clk_fast);
      if (!rst) begin
        if (slot_o && ins_exp.size() > 0) begin
          last_ins = ins_exp.pop_front();
          if (last_ins.chk) check(last_ins.req, instr_o, last_ins.val);
        end else if (!slot_o && dat_exp.size() > 0) begin
          exp_t e = dat_exp.pop_front();
          if (e.chk) check(e.req, rdata_o, e.val);
          if (last_ins.chk) check("R3 fetch word held over data slot", instr_o, last_ins.val);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_fast);
    check("R1 reset slot", {31'd0, slot_o}, 32'd0);
    check("R1 reset instr", instr_o, 32'd0);
    check("R1 reset rdata", rdata_o, 32'd0);
    rst = 1'b0;
    #1;

    // R5 R8: fill words 0..15 with distinct halves, fetching the word written before.
    for (int i = 0; i < 16; i++) begin
      cycle(32'(i == 0 ? 0 : i - 1), 32'(i), 1'b1,
            {16'hC000 + 16'(i * 3), 16'h0300 + 16'(i * 7)}, 1'b0, "R5 R8 fill");
    end
    // R4 R8: read back in another order while fetching from the far end.
    for (int i = 0; i < 16; i++) begin
      cycle(32'(15 - i), 32'((i * 5) % 16), 1'b0, 32'h0, 1'b0, "R4 R8 read");
    end
    // R7: fetch and write the same word in one cycle; next fetch sees the new word.
    cycle(32'd6, 32'd6, 1'b1, 32'hDEAD_BEEF, 1'b0, "R7 same-address");
    cycle(32'd6, 32'd6, 1'b0, 32'h0, 1'b0, "R7 after write");
    // R6: write enable high in the fetch slot only stores nothing.
    cycle(32'd2, 32'd9, 1'b1, 32'h1234_5678, 1'b1, "R6 early enable");
    cycle(32'd9, 32'd9, 1'b0, 32'h0, 1'b0, "R6 word unchanged");
    // R9: wrap of data and fetch addresses.
    cycle(32'd1, 32'(DEPTH + 20), 1'b1, 32'h0F0F_A5A5, 1'b0, "R9 wrap store");
    cycle(32'(2 * DEPTH + 20), 32'd20, 1'b0, 32'h0, 1'b0, "R9 wrap fetch and load");
    cycle(32'd20, 32'(3 * DEPTH + 20), 1'b0, 32'h0, 1'b0, "R9 wrap load");
    // R5: back-to-back stores keep rdata steady, then read both.
    cycle(32'd3, 32'd30, 1'b1, 32'h8001_7FFE, 1'b0, "R5 store a");
    cycle(32'd30, 32'd31, 1'b1, 32'hFFFF_0000, 1'b0, "R5 store b");
    cycle(32'd31, 32'd30, 1'b0, 32'h0, 1'b0, "R8 read a");
    cycle(32'd0, 32'd31, 1'b0, 32'h0, 1'b0, "R8 read b");

    repeat (4) @(negedge clk_fast);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule